// File: doc/BRIEF.md
# Predicated Element Step Skipper

This block walks a vector loop under predication. It receives a source mask, a destination mask, a vector length and the mode flags for one operation through a ready/valid handshake. It then presents pairs of source and destination element indices, one pair per issued element. Each index lands on the next element whose mask bit is set, so masked-out elements are skipped in a single cycle rather than one at a time.

The search works like this. Mask bits below the search start and at or above the vector length are cleared. A sentinel bit is set at the vector length, and a priority encoder picks the lowest set bit. An index with no set bit left therefore stops exactly at the vector length. A zeroing flag on either side turns skipping off for that side, so every element is visited and can be treated as a zeroed lane. After every step change a one-cycle pulse tells downstream decode to run again. When both indices reach the vector length the loop ends with a one-cycle done pulse, the indices return to zero and the block waits for the next masks. In scalar mode one element at index 0 is issued, whatever the masks hold.

Top module: `pred_stepper`

## Requirements
- R1: `mask_ready_o` is 1 exactly while no loop is running. Masks, vector length and flags are captured on a cycle with `mask_valid_i` and `mask_ready_o` both 1. While a loop runs, `mask_valid_i` has no effect on the steps or outputs.
- R2: On the first element of a vector loop, each step equals the index of the lowest set bit of its own mask below the vector length. Source and destination are found independently.
- R3: A step with no qualifying set bit left equals the vector length. A step never exceeds the vector length.
- R4: After `advance_i` is seen while `elem_valid_o` is 1, each step moves to the lowest set mask bit strictly above its current value, or to the vector length if there is none. A step already at the vector length stays there.
- R5: When `src_zero_i` (or `dst_zero_i`) was captured as 1, that side visits every index from 0 to the vector length minus 1 in order, ignoring its mask.
- R6: `redecode_o` is 1 for one cycle, in the first cycle a new step pair is shown, whenever that pair differs from the previous pair (the previous pair is 0,0 at loop start). It never rises on the final advance.
- R7: When both next steps equal the vector length, `done_o` is 1 for exactly one cycle. In that cycle both steps read 0, `elem_valid_o` is 0 and `mask_ready_o` is 1.
- R8: A vector loop with vector length 0, or with no qualifying bits on either side, raises `done_o` in the cycle after the handshake and issues no element.
- R9: With `vec_mode_i` captured as 0, exactly one element is issued, with both steps at 0. `done_o` follows the advance.
- R10: A vector length above W is treated as W.

Ports, in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_valid_i | input | 1 | Masks and loop parameters are valid |
| mask_ready_o | output | 1 | Block waits for masks |
| src_mask_i | input | W | Source predicate mask, bit i for element i |
| dst_mask_i | input | W | Destination predicate mask, bit i for element i |
| vl_i | input | $clog2(W+1) | Vector length, 0 to W |
| vec_mode_i | input | 1 | 1 = vector loop, 0 = single scalar element |
| src_zero_i | input | 1 | Source zeroing: do not skip on the source side |
| dst_zero_i | input | 1 | Destination zeroing: do not skip on the destination side |
| advance_i | input | 1 | Current element consumed, move on |
| src_step_o | output | $clog2(W+1) | Current source element index |
| dst_step_o | output | $clog2(W+1) | Current destination element index |
| elem_valid_o | output | 1 | An element pair is being presented |
| redecode_o | output | 1 | Step pair changed, decode must rerun |
| done_o | output | 1 | Loop complete, one-cycle pulse |

## Verification
Two events can fall in the same cycle. Mask acceptance and loop completion coincide when the vector length is 0, or when neither mask has a set bit below it. Completion can also land on the same advance that would otherwise move one side that is already parked at the vector length. The bench provokes the first case with empty masks, with a zero length and with set bits only above the length. It provokes the second case with a sparse source mask paired with a one-bit destination mask. It judges both by requiring `done_o` without any `elem_valid_o` or `redecode_o`, with both steps at 0 and ready back at 1.

// File: rtl/pstep_pkg.sv
package pstep_pkg;
   typedef enum logic [0:0] {
      PS_WAIT = 1'b0,
      PS_RUN  = 1'b1
   } pstep_state_t;

   localparam int unsigned PS_SIDES = 2;
   localparam int unsigned PS_SRC   = 0;
   localparam int unsigned PS_DST   = 1;
endpackage

// File: rtl/pstep_prio.sv
module pstep_prio #(
   parameter int unsigned N  = 65,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx
);
   // lowest set bit wins; caller guarantees at least one bit set
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/pstep_find.sv
module pstep_find #(
   parameter int unsigned W  = 64,
   localparam int unsigned LW = $clog2(W + 1)
) (
   input  logic [W-1:0]  mask,
   input  logic [LW-1:0] start,
   input  logic [LW-1:0] vl,
   input  logic          zero,
   output logic [LW-1:0] nxt
);
   logic [W:0]    cand;
   logic [LW-1:0] enc;

   for (genvar g = 0; g <= W; g++) begin : g_cand
      if (g < W) begin : g_lane
         assign cand[g] = (LW'(g) == vl) |
                          (mask[g] & (LW'(g) >= start) & (LW'(g) < vl));
      end else begin : g_top
         assign cand[g] = (LW'(g) == vl);
      end
   end

   pstep_prio #(.N(W + 1)) u_prio (
      .req (cand),
      .idx (enc)
   );

   always_comb begin
      if (zero) nxt = (start < vl) ? start : vl;
      else      nxt = enc;
   end
endmodule

// File: rtl/pred_stepper.sv
module pred_stepper #(
   parameter int unsigned W  = 64,
   localparam int unsigned LW = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mask_valid_i,
   output logic          mask_ready_o,
   input  logic [W-1:0]  src_mask_i,
   input  logic [W-1:0]  dst_mask_i,
   input  logic [LW-1:0] vl_i,
   input  logic          vec_mode_i,
   input  logic          src_zero_i,
   input  logic          dst_zero_i,
   input  logic          advance_i,
   output logic [LW-1:0] src_step_o,
   output logic [LW-1:0] dst_step_o,
   output logic          elem_valid_o,
   output logic          redecode_o,
   output logic          done_o
);
   import pstep_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("pred_stepper: W must be at least 2");
   end

   pstep_state_t  state_q;
   logic [W-1:0]  smask_q, dmask_q;
   logic [LW-1:0] vl_q, src_q, dst_q;
   logic          vec_q, sz_q, dz_q;
   logic          redec_q, done_q;

   logic [LW-1:0] vl_in;
   logic [LW-1:0] f_vl;
   logic [W-1:0]  f_mask  [PS_SIDES];
   logic [LW-1:0] f_cur   [PS_SIDES];
   logic [LW-1:0] f_start [PS_SIDES];
   logic          f_zero  [PS_SIDES];
   logic [LW-1:0] f_next  [PS_SIDES];
   logic          all_end;
   logic          moved;

   assign vl_in = (vl_i > LW'(W)) ? LW'(W) : vl_i;

   // waiting: search from 0 over incoming masks; running: search above current
   always_comb begin
      if (state_q == PS_WAIT) begin
         f_vl             = vl_in;
         f_mask[PS_SRC]   = src_mask_i;
         f_mask[PS_DST]   = dst_mask_i;
         f_zero[PS_SRC]   = src_zero_i;
         f_zero[PS_DST]   = dst_zero_i;
      end else begin
         f_vl             = vl_q;
         f_mask[PS_SRC]   = smask_q;
         f_mask[PS_DST]   = dmask_q;
         f_zero[PS_SRC]   = sz_q;
         f_zero[PS_DST]   = dz_q;
      end
      f_cur[PS_SRC] = src_q;
      f_cur[PS_DST] = dst_q;
   end

   for (genvar s = 0; s < PS_SIDES; s++) begin : g_side
      always_comb begin
         if (state_q == PS_WAIT)      f_start[s] = '0;
         else if (f_cur[s] >= f_vl)   f_start[s] = f_vl;
         else                         f_start[s] = f_cur[s] + LW'(1);
      end

      pstep_find #(.W(W)) u_find (
         .mask  (f_mask[s]),
         .start (f_start[s]),
         .vl    (f_vl),
         .zero  (f_zero[s]),
         .nxt   (f_next[s])
      );
   end

   assign all_end = (f_next[PS_SRC] == f_vl) && (f_next[PS_DST] == f_vl);
   assign moved   = (f_next[PS_SRC] != src_q) || (f_next[PS_DST] != dst_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_WAIT;
         smask_q <= '0;
         dmask_q <= '0;
         vl_q    <= '0;
         vec_q   <= 1'b0;
         sz_q    <= 1'b0;
         dz_q    <= 1'b0;
         src_q   <= '0;
         dst_q   <= '0;
         redec_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         redec_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (state_q)
            PS_WAIT: begin
               if (mask_valid_i) begin
                  smask_q <= src_mask_i;
                  dmask_q <= dst_mask_i;
                  vl_q    <= vl_in;
                  vec_q   <= vec_mode_i;
                  sz_q    <= src_zero_i;
                  dz_q    <= dst_zero_i;
                  if (!vec_mode_i) begin
                     src_q   <= '0;
                     dst_q   <= '0;
                     state_q <= PS_RUN;
                  end else if (all_end) begin
                     done_q  <= 1'b1;
                  end else begin
                     src_q   <= f_next[PS_SRC];
                     dst_q   <= f_next[PS_DST];
                     redec_q <= moved;
                     state_q <= PS_RUN;
                  end
               end
            end
            PS_RUN: begin
               if (advance_i) begin
                  if (!vec_q || all_end) begin
                     done_q  <= 1'b1;
                     src_q   <= '0;
                     dst_q   <= '0;
                     state_q <= PS_WAIT;
                  end else begin
                     src_q   <= f_next[PS_SRC];
                     dst_q   <= f_next[PS_DST];
                     redec_q <= moved;
                  end
               end
            end
            default: state_q <= PS_WAIT;
         endcase
      end
   end

   assign mask_ready_o = (state_q == PS_WAIT);
   assign elem_valid_o = (state_q == PS_RUN);
   assign src_step_o   = src_q;
   assign dst_step_o   = dst_q;
   assign redecode_o   = redec_q;
   assign done_o       = done_q;
endmodule

// File: rtl/pstep_chk.sv
module pstep_chk #(
   parameter int unsigned W  = 64,
   localparam int unsigned LW = $clog2(W + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mask_ready_o,
   input logic          advance_i,
   input logic [LW-1:0] src_step_o,
   input logic [LW-1:0] dst_step_o,
   input logic          elem_valid_o,
   input logic          redecode_o,
   input logic          done_o,
   input logic [W-1:0]  smask_q,
   input logic [W-1:0]  dmask_q,
   input logic [LW-1:0] vl_q,
   input logic          vec_q,
   input logic          sz_q,
   input logic          dz_q
);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid_o && !advance_i) |=>
         (elem_valid_o && $stable(src_step_o) && $stable(dst_step_o)));

   assert_src_on_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid_o && vec_q && !sz_q && (src_step_o < vl_q)) |->
         (((smask_q >> src_step_o) & W'(1)) != '0));

   assert_dst_on_set_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid_o && vec_q && !dz_q && (dst_step_o < vl_q)) |->
         (((dmask_q >> dst_step_o) & W'(1)) != '0));

   assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid_o |-> ((src_step_o <= vl_q) && (dst_step_o <= vl_q)));

   assert_redecode_with_elem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redecode_o |-> elem_valid_o);

   assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((src_step_o == '0) && (dst_step_o == '0) && mask_ready_o));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_scalar_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid_o && !vec_q) |-> ((src_step_o == '0) && (dst_step_o == '0)));
endmodule

bind pred_stepper pstep_chk #(.W(W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mask_ready_o (mask_ready_o),
   .advance_i    (advance_i),
   .src_step_o   (src_step_o),
   .dst_step_o   (dst_step_o),
   .elem_valid_o (elem_valid_o),
   .redecode_o   (redecode_o),
   .done_o       (done_o),
   .smask_q      (smask_q),
   .dmask_q      (dmask_q),
   .vl_q         (vl_q),
   .vec_q        (vec_q),
   .sz_q         (sz_q),
   .dz_q         (dz_q)
);

// File: tb/sim_pred_stepper.sv
`timescale 1ns/1ps
module sim_pred_stepper;
   localparam int unsigned W  = 64;
   localparam int unsigned LW = $clog2(W + 1);
   localparam int NROW = 8;

   // stimulus table: masks, length, zero flags, expected element count
   localparam logic [63:0] T_SM [NROW] = '{64'hB2, 64'h0, 64'h8000_0000_0000_0000,
      64'hF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'hF00, 64'h3};
   localparam logic [63:0] T_DM [NROW] = '{64'hFF, 64'h0, 64'h1,
      64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'hF00, 64'h0};
   localparam int T_VL [NROW] = '{8, 10, 64, 6, 0, 100, 8, 3};
   localparam bit T_SZ [NROW] = '{0, 0, 0, 1, 0, 0, 0, 0};
   localparam bit T_DZ [NROW] = '{0, 0, 0, 0, 0, 0, 0, 1};
   localparam int T_N  [NROW] = '{8, 0, 1, 6, 0, 2, 0, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mask_valid_i = 1'b0;
   logic          mask_ready_o;
   logic [W-1:0]  src_mask_i = '0;
   logic [W-1:0]  dst_mask_i = '0;
   logic [LW-1:0] vl_i = '0;
   logic          vec_mode_i = 1'b0;
   logic          src_zero_i = 1'b0;
   logic          dst_zero_i = 1'b0;
   logic          advance_i = 1'b0;
   logic [LW-1:0] src_step_o, dst_step_o;
   logic          elem_valid_o, redecode_o, done_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pred_stepper #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .mask_valid_i(mask_valid_i), .mask_ready_o(mask_ready_o),
      .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i), .vl_i(vl_i),
      .vec_mode_i(vec_mode_i), .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i),
      .advance_i(advance_i), .src_step_o(src_step_o), .dst_step_o(dst_step_o),
      .elem_valid_o(elem_valid_o), .redecode_o(redecode_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // reference search written from the requirements: linear scan
   function automatic int ref_next(input logic [63:0] m, input int start, input int vle, input bit z);
      if (z) return (start < vle) ? start : vle;
      for (int i = start; i < vle; i++) if (m[i]) return i;
      return vle;
   endfunction

   function automatic string step_tag(input bit first, input bit z, input int v, input int vle, input int vl);
      if (vl > W)   return "R10";
      if (z)        return "R5";
      if (v == vle) return "R3";
      if (first)    return "R2";
      return "R4";
   endfunction

   task automatic run_loop(input logic [63:0] sm, input logic [63:0] dm, input int vl,
                           input bit sz, input bit dz, input bit vec, input int exp_n);
      int vle, es, ed, ps, pd, n;
      bit first;
      vle = (vl > W) ? W : vl;
      @(negedge clk);
      src_mask_i = sm; dst_mask_i = dm; vl_i = LW'(vl);
      src_zero_i = sz; dst_zero_i = dz; vec_mode_i = vec;
      mask_valid_i = 1'b1;
      @(negedge clk);
      mask_valid_i = 1'b0;
      if (vec) begin
         es = ref_next(sm, 0, vle, sz);
         ed = ref_next(dm, 0, vle, dz);
      end else begin
         es = 0; ed = 0;
      end
      n = 0; ps = 0; pd = 0; first = 1'b1;
      if (vec && es == vle && ed == vle) begin
         chk("R8 done at accept", done_o, 1);
         chk("R8 no element", elem_valid_o, 0);
         chk("R8 no redecode", redecode_o, 0);
      end else begin
         forever begin
            chk("R1 elem valid", elem_valid_o, 1);
            chk("R1 ready low", mask_ready_o, 0);
            if (vec) begin
               chk(step_tag(first, sz, es, vle, vl), int'(src_step_o), es);
               chk(step_tag(first, dz, ed, vle, vl), int'(dst_step_o), ed);
            end else begin
               chk("R9 src step", int'(src_step_o), 0);
               chk("R9 dst step", int'(dst_step_o), 0);
            end
            chk("R6 redecode", redecode_o, (vec && (es != ps || ed != pd)) ? 1 : 0);
            n++; ps = es; pd = ed; first = 1'b0;
            advance_i = 1'b1;
            @(negedge clk);
            advance_i = 1'b0;
            if (!vec) break;
            es = ref_next(sm, (ps >= vle) ? vle : ps + 1, vle, sz);
            ed = ref_next(dm, (pd >= vle) ? vle : pd + 1, vle, dz);
            if (es == vle && ed == vle) break;
         end
         chk("R7 done", done_o, 1);
         chk("R6 no redecode at end", redecode_o, 0);
      end
      chk("R7 ready back", mask_ready_o, 1);
      chk("R7 src cleared", int'(src_step_o), 0);
      chk("R7 dst cleared", int'(dst_step_o), 0);
      chk(vec ? "R2 element count" : "R9 element count", n, exp_n);
      @(negedge clk);
      chk("R7 done single cycle", done_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ready", mask_ready_o, 1);
      chk("R7 reset done", done_o, 0);
      chk("R1 reset elem", elem_valid_o, 0);
      chk("R3 reset src", int'(src_step_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int r = 0; r < NROW; r++)
         run_loop(T_SM[r], T_DM[r], T_VL[r], T_SZ[r], T_DZ[r], 1'b1, T_N[r]);

      // scalar mode: masks and length have no effect
      run_loop(64'h0, 64'h0, 0, 1'b0, 1'b0, 1'b0, 1);
      run_loop(64'hF0, 64'hF0, 9, 1'b0, 1'b0, 1'b0, 1);

      // R1: valid during a running loop is ignored
      @(negedge clk);
      src_mask_i = 64'hF; dst_mask_i = 64'hF; vl_i = LW'(4);
      src_zero_i = 0; dst_zero_i = 0; vec_mode_i = 1;
      mask_valid_i = 1'b1;
      @(negedge clk);
      src_mask_i = 64'h0; dst_mask_i = 64'h0; vl_i = '0;
      @(negedge clk);
      mask_valid_i = 1'b0;
      chk("R1 ignored valid ready", mask_ready_o, 0);
      chk("R1 ignored valid elem", elem_valid_o, 1);
      chk("R1 ignored valid src", int'(src_step_o), 0);
      chk("R1 ignored valid done", done_o, 0);
      for (int k = 1; k < 4; k++) begin
         advance_i = 1'b1;
         @(negedge clk);
         advance_i = 1'b0;
         chk("R1 kept masks src", int'(src_step_o), k);
         chk("R1 kept masks dst", int'(dst_step_o), k);
      end
      advance_i = 1'b1;
      @(negedge clk);
      advance_i = 1'b0;
      chk("R7 done after kept loop", done_o, 1);
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule